// File: doc/BRIEF.md
# Start-of-Frame Delimiter Hunt Controller

This block controls the receiver while it looks for the start-of-frame delimiter. The delimiter search begins once preamble acquisition has finished. On every symbol strobe the block counts one symbol. It also shifts the received, descrambled bit into a 16-bit pattern register.

When the delimiter pattern appears, the block pulses a found flag and enters the frame state. If a programmable number of symbols passes first, the block pulses a return-to-acquisition flag and sends the receiver back to acquisition. Without that limit, a lost delimiter would stall the receiver forever.

The limit is normally set to the longest preamble length in use on the network plus 16 symbols. A limit of zero turns the timeout off. An external frame-end input ends the frame and returns the controller to acquisition.

Top module: `sfd_hunt_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises, `state_o` reads 0 (IDLE) and both `sfd_found_o` and `reacq_o` are low.
- R2: State codes are 0 IDLE, 1 ACQUIRE, 2 SFD_SEARCH and 3 FRAME. In IDLE, the first `sym_stb_i` moves the state to ACQUIRE at the next clock edge.
- R3: In ACQUIRE, `acq_done_i` moves the state to SFD_SEARCH at the next edge and clears the symbol count. In any other state, `acq_done_i` has no effect.
- R4: Each `sym_stb_i` shifts `rx_bit_i` into the LSB of a 16-bit register. The delimiter is the register value 0xF3A0, so it arrives most significant bit first.
- R5: In SFD_SEARCH, a strobe that completes 0xF3A0 raises `sfd_found_o` for exactly one cycle after that edge, and the state becomes FRAME in the same cycle.
- R6: In FRAME, `frame_end_i` returns the state to ACQUIRE at the next edge.
- R7: With `timeout_i` = N (N > 0), the Nth strobe counted in SFD_SEARCH without a match raises `reacq_o` for one cycle after that edge. The state returns to ACQUIRE in the same cycle. Strobes 1 to N-1 change nothing.
- R8: With `timeout_i` = 0, SFD_SEARCH never times out, whatever the number of strobes.
- R9: If a match and the expiry fall on the same strobe, the match wins: `sfd_found_o` pulses, the state becomes FRAME and `reacq_o` stays low.
- R10: The pattern register is cleared when SFD_SEARCH is entered. Bits received before that do not count towards a match.
- R11: Outside SFD_SEARCH, a completed 0xF3A0 pattern raises no `sfd_found_o`, and strobes are not counted towards the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_stb_i | input | 1 | One-cycle strobe per received symbol |
| rx_bit_i | input | 1 | Descrambled received bit, valid with the strobe |
| acq_done_i | input | 1 | Preamble acquisition finished |
| frame_end_i | input | 1 | Current frame has ended |
| timeout_i | input | TIMEOUT_W | Search limit in symbols; 0 disables it |
| state_o | output | 2 | Controller state code |
| sfd_found_o | output | 1 | One-cycle pulse when the delimiter is matched |
| reacq_o | output | 1 | One-cycle pulse on search timeout |

## Verification
The assertions assume that the control inputs are synchronous to `clk_i`. They also assume that `timeout_i` stays constant for at least one cycle before any strobe that could expire the search. The entry check further relies on `acq_done_i` being the only way into SFD_SEARCH.

The stimulus drives every input on the falling clock edge and holds each strobe for a single cycle. It changes `timeout_i` only while the controller is outside SFD_SEARCH. It pulses `acq_done_i` and `frame_end_i` for one cycle at a time, with no strobe in the same cycle.

// File: rtl/sfd_hunt_pkg.sv
package sfd_hunt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_SRCH  = 2'd2,
    ST_FRAME = 2'd3
  } hunt_state_e;

  localparam int unsigned DLM_W = 16;
  localparam logic [DLM_W-1:0] DLM_PATTERN = 16'hF3A0;
endpackage

// File: rtl/sfd_shift_match.sv
module sfd_shift_match #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] PATTERN = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic hit_o
);
  logic [W-1:0] sh_q, sh_nxt;

  assign sh_nxt = {sh_q[W-2:0], bit_i};
  // hit reflects the value this strobe would store
  assign hit_o  = shift_i && (sh_nxt == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (shift_i) sh_q <= sh_nxt;
  end
endmodule

// File: rtl/sym_timeout_cnt.sv
module sym_timeout_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  localparam logic [CW:0] CNT_MAX = {1'b0, {CW{1'b1}}};

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = inc_i && (limit_i != '0) && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i && (cnt_inc <= CNT_MAX)) cnt_q <= cnt_inc[CW-1:0];
  end
endmodule

// File: rtl/sfd_hunt_ctrl.sv
module sfd_hunt_ctrl
  import sfd_hunt_pkg::*;
#(
  parameter int unsigned TIMEOUT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_stb_i,
  input  logic                 rx_bit_i,
  input  logic                 acq_done_i,
  input  logic                 frame_end_i,
  input  logic [TIMEOUT_W-1:0] timeout_i,
  output logic [1:0]           state_o,
  output logic                 sfd_found_o,
  output logic                 reacq_o
);
  hunt_state_e st_q, st_d;
  logic in_srch, enter_srch, hit, expire;
  logic found_d, reacq_d, found_q, reacq_q;

  assign in_srch    = (st_q == ST_SRCH);
  assign enter_srch = (st_q == ST_ACQ) && acq_done_i;

  sfd_shift_match #(.W(DLM_W), .PATTERN(DLM_PATTERN)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (enter_srch),
    .shift_i (sym_stb_i),
    .bit_i   (rx_bit_i),
    .hit_o   (hit)
  );

  sym_timeout_cnt #(.CW(TIMEOUT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (enter_srch),
    .inc_i    (sym_stb_i && in_srch),
    .limit_i  (timeout_i),
    .expire_o (expire)
  );

  always_comb begin
    st_d    = st_q;
    found_d = 1'b0;
    reacq_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (sym_stb_i) st_d = ST_ACQ;
      ST_ACQ:   if (acq_done_i) st_d = ST_SRCH;
      ST_SRCH: begin
        // match outranks expiry on the same symbol
        if (hit) begin
          st_d    = ST_FRAME;
          found_d = 1'b1;
        end else if (expire) begin
          st_d    = ST_ACQ;
          reacq_d = 1'b1;
        end
      end
      ST_FRAME: if (frame_end_i) st_d = ST_ACQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      found_q <= 1'b0;
      reacq_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      found_q <= found_d;
      reacq_q <= reacq_d;
    end
  end

  assign state_o     = st_q;
  assign sfd_found_o = found_q;
  assign reacq_o     = reacq_q;
endmodule

// File: rtl/sfd_hunt_ctrl_chk.sv
module sfd_hunt_ctrl_chk #(
  parameter int unsigned TIMEOUT_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sym_stb_i,
  input logic                 acq_done_i,
  input logic                 frame_end_i,
  input logic [TIMEOUT_W-1:0] timeout_i,
  input logic [1:0]           state_o,
  input logic                 sfd_found_o,
  input logic                 reacq_o
);
  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && sym_stb_i) |=> state_o == 2'd1); // R2
  AST_SRCH_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> ($past(state_o) == 2'd1 && $past(acq_done_i))); // R3
  AST_FOUND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_found_o |=> !sfd_found_o); // R5
  AST_FOUND_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_found_o |-> (state_o == 2'd3 && $past(state_o) == 2'd2)); // R5
  AST_FRAME_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && frame_end_i) |=> state_o == 2'd1); // R6
  AST_REACQ_FROM_SRCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reacq_o |-> (state_o == 2'd1 && $past(state_o) == 2'd2 && $past(sym_stb_i))); // R7
  AST_ZERO_NO_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reacq_o |-> $past(timeout_i) != '0); // R8
  AST_NO_DUAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sfd_found_o && reacq_o)); // R9
endmodule

bind sfd_hunt_ctrl sfd_hunt_ctrl_chk #(.TIMEOUT_W(TIMEOUT_W)) u_chk (.*);

// File: tb/sfd_hunt_ctrl_bench.sv
module sfd_hunt_ctrl_bench;
  localparam int TW = 8;
  localparam logic [15:0] DLM = 16'hF3A0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, rxb = 1'b0, acq = 1'b0, fend = 1'b0;
  logic [TW-1:0] tmo = '0;
  logic [1:0] st;
  logic found, reacq;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sfd_hunt_ctrl #(.TIMEOUT_W(TW)) u_sfd_hunt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sym_stb_i(stb), .rx_bit_i(rxb),
    .acq_done_i(acq), .frame_end_i(fend), .timeout_i(tmo),
    .state_o(st), .sfd_found_o(found), .reacq_o(reacq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle strobe; returns after the edge, outputs already updated
  task automatic send_bit(input logic b);
    @(negedge clk); stb = 1'b1; rxb = b;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic pulse_acq();
    @(negedge clk); acq = 1'b1;
    @(negedge clk); acq = 1'b0;
  endtask

  task automatic pulse_fend();
    @(negedge clk); fend = 1'b1;
    @(negedge clk); fend = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", st, 0); chk("R1 found", found, 0); chk("R1 reacq", reacq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after release", st, 0);
    pulse_acq();
    chk("R3 acq_done ignored in IDLE", st, 0);
  endtask

  task automatic t_idle_exit();
    send_bit(1'b1);
    chk("R2 IDLE->ACQUIRE", st, 1);
  endtask

  task automatic t_outside_search();
    int hits = 0;
    for (int i = 15; i >= 0; i--) begin
      send_bit(DLM[i]);
      hits += found;
    end
    chk("R11 no found in ACQUIRE", hits, 0);
    chk("R11 still ACQUIRE", st, 1);
  endtask

  task automatic t_match();
    int early = 0;
    tmo = '0;
    pulse_acq();
    chk("R3 ACQUIRE->SEARCH", st, 2);
    for (int i = 0; i < 20; i++) begin
      send_bit(i[0] ? 1'b0 : 1'b1);
      early += found;
    end
    for (int i = 15; i >= 1; i--) begin
      send_bit(DLM[i]);
      early += found;
    end
    chk("R4 no early match", early, 0);
    send_bit(DLM[0]);
    chk("R5 found pulse", found, 1);
    chk("R5 state FRAME", st, 3);
    @(negedge clk);
    chk("R5 pulse one cycle", found, 0);
    pulse_acq();
    chk("R3 acq_done ignored in FRAME", st, 3);
    pulse_fend();
    chk("R6 FRAME->ACQUIRE", st, 1);
    pulse_fend();
    chk("R6 frame_end ignored in ACQUIRE", st, 1);
  endtask

  task automatic t_timeout();
    int pre = 0;
    tmo = 8'd10;
    pulse_acq();
    for (int i = 0; i < 9; i++) begin
      send_bit(1'b0);
      pre += reacq;
    end
    chk("R7 no reacq before limit", pre, 0);
    chk("R7 still SEARCH", st, 2);
    send_bit(1'b0);
    chk("R7 reacq pulse", reacq, 1);
    chk("R7 state ACQUIRE", st, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", reacq, 0);
    // count cleared on re-entry
    pulse_acq();
    pre = 0;
    for (int i = 0; i < 9; i++) begin
      send_bit(1'b0);
      pre += reacq;
    end
    chk("R3 count cleared on entry", pre, 0);
    send_bit(1'b0);
    chk("R7 second expiry", reacq, 1);
  endtask

  task automatic t_disabled();
    int r = 0;
    tmo = '0;
    pulse_acq();
    for (int i = 0; i < 300; i++) begin
      send_bit(1'b0);
      r += reacq;
    end
    chk("R8 no reacq with limit 0", r, 0);
    chk("R8 still SEARCH", st, 2);
    for (int i = 15; i >= 0; i--) send_bit(DLM[i]);
    chk("R5 found after long search", st, 3);
    pulse_fend();
  endtask

  task automatic t_tie();
    tmo = 8'd16;
    pulse_acq();
    for (int i = 15; i >= 0; i--) send_bit(DLM[i]);
    chk("R9 match wins found", found, 1);
    chk("R9 match wins no reacq", reacq, 0);
    chk("R9 state FRAME", st, 3);
    pulse_fend();
  endtask

  task automatic t_clear();
    int f = 0;
    tmo = '0;
    for (int i = 15; i >= 8; i--) send_bit(DLM[i]);
    pulse_acq();
    for (int i = 7; i >= 0; i--) begin
      send_bit(DLM[i]);
      f += found;
    end
    chk("R10 stale bits ignored", f, 0);
    chk("R10 still SEARCH", st, 2);
    for (int i = 15; i >= 0; i--) send_bit(DLM[i]);
    chk("R10 full pattern matches", found, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_exit();
    t_outside_search();
    t_match();
    t_timeout();
    t_disabled();
    t_tie();
    t_clear();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule